// File: doc/BRIEF.md
# Register Rename Map with Undo History

This block renames one instruction per cycle for an out-of-order core. It keeps a table from flattened architectural registers to physical registers. A FIFO free list holds the unused physical registers, and a ready scoreboard has one bit per physical register. For each source operand it returns the physical register that currently holds the value and whether that value has been written back. For a destination it hands out the oldest free physical register and reports the mapping being replaced. It also records an undo entry, so that a later squash can roll the table back and a later commit can release the replaced register.

Integer architectural indices sit below a floating-point base. They are flattened with a bank-select input before any lookup, so that each bank has its own set of integer registers. Floating-point indices keep their value. The physical pool size is the sum of an integer count and a floating-point count. After reset the pool holds one register for each flattened architectural register, plus a set of spares that start on the free list.

A squash request starts a walk that takes one history entry per cycle, newest first, and stops at the first entry that is not younger than the squash point. A commit request retires the oldest entries, one per cycle, while their sequence numbers are at or below the commit point. Sequence numbers compare as plain unsigned values.

Top module: `rn_map`

## Requirements
- R1: An integer index (below `INT_ARCH`) flattens to itself in bank 0, and to `idx + bank*INT_ARCH + FP_ARCH` in any other bank below `NUM_BANKS`. A floating-point index (from `INT_ARCH` up to `INT_ARCH+FP_ARCH-1`) keeps its value. A bank value at or above `NUM_BANKS` acts as bank 0.
- R2: Each source slot returns, combinationally, the current physical mapping of its flattened index on `src_phys_o` (slot g at bits `g*PHYS_W`) and that register's scoreboard bit on `src_rdy_o[g]`. The values come from the state before any rename that happens in the same cycle.
- R3: `dst_phys_o` shows the oldest free physical register, and `dst_prev_o` shows the current mapping of the flattened destination. An accepted rename (`ren_valid_i`, `dst_valid_i` and `ren_ready_o` all high) installs `dst_phys_o` as the new mapping and clears its scoreboard bit, both from the next cycle on.
- R4: A writeback (`wb_valid_i`) sets the scoreboard bit of `wb_phys_i`, and sources see the bit from the next cycle.
- R5: Every accepted rename pushes an entry {sequence, flattened index, new register, previous register}. `ren_ready_o` is low while the history is full or the free list is empty, and a rename presented while it is low changes no mapping and allocates nothing.
- R6: After `squash_i`, the block walks one entry per cycle, newest first, while the entry's sequence is greater than `squash_seq_i`. Each step restores the previous mapping and returns the new register to the tail of the free list. `squash_busy_o` is high from the cycle after `squash_i` until the walk ends, and `ren_ready_o` is low during `squash_i` and during the walk.
- R7: While `commit_i` is high, one oldest entry per cycle with sequence at or below `commit_seq_i` is removed and its previous register is appended to the free list. An entry that is too young stays.
- R8: After reset, flattened register f maps to physical f, every scoreboard bit is set, the history is empty, and the free list holds the spare registers in ascending order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bank_i | input | BANK_W | Bank select used to flatten integer indices |
| ren_valid_i | input | 1 | An instruction is presented for rename |
| dst_valid_i | input | 1 | The instruction has a destination |
| src_idx_i | input | NUM_SRC*ARCH_W | Architectural source indices, slot g at bits g*ARCH_W |
| dst_idx_i | input | ARCH_W | Architectural destination index |
| seq_i | input | SEQ_W | Sequence number of the instruction |
| ren_ready_o | output | 1 | A rename can be accepted this cycle |
| src_phys_o | output | NUM_SRC*PHYS_W | Physical register of each source |
| src_rdy_o | output | NUM_SRC | Scoreboard bit of each source register |
| dst_phys_o | output | PHYS_W | Physical register a rename would allocate |
| dst_prev_o | output | PHYS_W | Current mapping of the destination |
| wb_valid_i | input | 1 | Writeback strobe |
| wb_phys_i | input | PHYS_W | Physical register written back |
| squash_i | input | 1 | Squash request |
| squash_seq_i | input | SEQ_W | Youngest sequence number that survives the squash |
| commit_i | input | 1 | Commit request, level sensitive |
| commit_seq_i | input | SEQ_W | Youngest sequence number that may retire |
| squash_busy_o | output | 1 | Squash walk in progress |

## Verification
The bench builds the block with four integer and four floating-point architectural registers, two banks, ten plus six physical registers (four spares) and a history depth of three. With three history entries against four spares, the history limit is the one that stalls rename, after only a handful of instructions. Wrapping the three-slot history pointers and the four-slot free list also takes only a few cycles. The twelve flattened registers put bank-1 integers above the floating-point range, so the same index given in two banks maps to different physical registers.

// File: rtl/rn_pkg.sv
`timescale 1ns/1ps
package rn_pkg;
  typedef enum logic {WALK_IDLE = 1'b0, WALK_SQUASH = 1'b1} walk_e;
endpackage

// File: rtl/rn_flatten.sv
`timescale 1ns/1ps
module rn_flatten #(
  parameter int INT_ARCH  = 8,
  parameter int FP_ARCH   = 8,
  parameter int NUM_BANKS = 2,
  parameter int ARCH_W    = 4,
  parameter int BANK_W    = 1,
  parameter int FLAT_W    = 5
) (
  input  logic [ARCH_W-1:0] arch_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [FLAT_W-1:0] flat_o
);
  logic pass;
  assign pass = (32'(arch_i) >= INT_ARCH) || (bank_i == '0) || (32'(bank_i) >= NUM_BANKS);

  always_comb begin
    if (pass) flat_o = FLAT_W'(arch_i);
    else      flat_o = FLAT_W'(32'(arch_i) + 32'(bank_i) * INT_ARCH + FP_ARCH);
  end
endmodule

// File: rtl/rn_free_list.sv
`timescale 1ns/1ps
module rn_free_list #(
  parameter int DEPTH  = 8,
  parameter int BASE   = 24,
  parameter int PHYS_W = 5,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pop_i,
  input  logic              push_i,
  input  logic [PHYS_W-1:0] push_id_i,
  output logic [PHYS_W-1:0] head_o,
  output logic              empty_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PHYS_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0]  rd_q, wr_q;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= PHYS_W'(BASE + i);
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= CNT_W'(DEPTH);
    end else begin
      if (push_i) begin
        slot_q[wr_q] <= push_id_i;
        wr_q         <= nxt(wr_q);
      end
      if (pop_i) rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  assign head_o  = slot_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/rn_history.sv
`timescale 1ns/1ps
module rn_history #(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int FLAT_W = 5,
  parameter int PHYS_W = 5,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [SEQ_W-1:0]  push_seq_i,
  input  logic [FLAT_W-1:0] push_arch_i,
  input  logic [PHYS_W-1:0] push_new_i,
  input  logic [PHYS_W-1:0] push_prev_i,
  input  logic              pop_yng_i,
  input  logic              pop_old_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [SEQ_W-1:0]  old_seq_o,
  output logic [PHYS_W-1:0] old_prev_o,
  output logic [SEQ_W-1:0]  yng_seq_o,
  output logic [FLAT_W-1:0] yng_arch_o,
  output logic [PHYS_W-1:0] yng_new_o,
  output logic [PHYS_W-1:0] yng_prev_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef struct packed {
    logic [SEQ_W-1:0]  seq;
    logic [FLAT_W-1:0] arch;
    logic [PHYS_W-1:0] nphys;
    logic [PHYS_W-1:0] pphys;
  } hent_t;

  hent_t            ent_q [DEPTH];
  logic [PTR_W-1:0] head_q, tail_q, yng_ptr;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign yng_ptr = (tail_q == '0) ? PTR_W'(DEPTH - 1) : tail_q - 1'b1;

  // push and pop_yng are exclusive by construction of the caller
  always_ff @(posedge clk_i) begin
    if (push_i) ent_q[tail_q] <= '{seq: push_seq_i, arch: push_arch_i,
                                   nphys: push_new_i, pphys: push_prev_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i)         tail_q <= nxt(tail_q);
      else if (pop_yng_i) tail_q <= yng_ptr;
      if (pop_old_i)      head_q <= nxt(head_q);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_yng_i) - CNT_W'(pop_old_i);
    end
  end

  assign cnt_o      = cnt_q;
  assign old_seq_o  = ent_q[head_q].seq;
  assign old_prev_o = ent_q[head_q].pphys;
  assign yng_seq_o  = ent_q[yng_ptr].seq;
  assign yng_arch_o = ent_q[yng_ptr].arch;
  assign yng_new_o  = ent_q[yng_ptr].nphys;
  assign yng_prev_o = ent_q[yng_ptr].pphys;
endmodule

// File: rtl/rn_map.sv
`timescale 1ns/1ps
module rn_map #(
  parameter int INT_ARCH   = 8,
  parameter int FP_ARCH    = 8,
  parameter int NUM_BANKS  = 2,
  parameter int INT_PHYS   = 20,
  parameter int FP_PHYS    = 12,
  parameter int NUM_SRC    = 2,
  parameter int HIST_DEPTH = 8,
  parameter int SEQ_W      = 16,
  localparam int ARCH_W    = $clog2(INT_ARCH + FP_ARCH),
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int FLAT_REGS = INT_ARCH * NUM_BANKS + FP_ARCH,
  localparam int FLAT_W    = $clog2(FLAT_REGS),
  localparam int PHYS_REGS = INT_PHYS + FP_PHYS,
  localparam int PHYS_W    = $clog2(PHYS_REGS),
  localparam int FREE_N    = PHYS_REGS - FLAT_REGS,
  localparam int FCNT_W    = $clog2(FREE_N + 1),
  localparam int HCNT_W    = $clog2(HIST_DEPTH + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [BANK_W-1:0]         bank_i,
  input  logic                      ren_valid_i,
  input  logic                      dst_valid_i,
  input  logic [NUM_SRC*ARCH_W-1:0] src_idx_i,
  input  logic [ARCH_W-1:0]         dst_idx_i,
  input  logic [SEQ_W-1:0]          seq_i,
  output logic                      ren_ready_o,
  output logic [NUM_SRC*PHYS_W-1:0] src_phys_o,
  output logic [NUM_SRC-1:0]        src_rdy_o,
  output logic [PHYS_W-1:0]         dst_phys_o,
  output logic [PHYS_W-1:0]         dst_prev_o,
  input  logic                      wb_valid_i,
  input  logic [PHYS_W-1:0]         wb_phys_i,
  input  logic                      squash_i,
  input  logic [SEQ_W-1:0]          squash_seq_i,
  input  logic                      commit_i,
  input  logic [SEQ_W-1:0]          commit_seq_i,
  output logic                      squash_busy_o
);
  import rn_pkg::*;

  logic [PHYS_W-1:0]  map_q [FLAT_REGS];
  logic [PHYS_REGS-1:0] rdy_q;
  walk_e              walk_q;
  logic [SEQ_W-1:0]   walk_seq_q;

  logic [FLAT_W-1:0]  src_flat [NUM_SRC];
  logic [FLAT_W-1:0]  dst_flat;

  logic               free_empty, free_push;
  logic [PHYS_W-1:0]  free_push_id;
  logic [FCNT_W-1:0]  free_cnt;
  logic [HCNT_W-1:0]  hist_cnt;
  logic [SEQ_W-1:0]   old_seq, yng_seq;
  logic [PHYS_W-1:0]  old_prev, yng_new, yng_prev;
  logic [FLAT_W-1:0]  yng_arch;
  logic               walking, hist_empty, hist_full, alloc, undo, retire;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic [PHYS_W-1:0] phys;
    rn_flatten #(.INT_ARCH(INT_ARCH), .FP_ARCH(FP_ARCH), .NUM_BANKS(NUM_BANKS),
                 .ARCH_W(ARCH_W), .BANK_W(BANK_W), .FLAT_W(FLAT_W)) u_flat (
      .arch_i (src_idx_i[g*ARCH_W +: ARCH_W]),
      .bank_i (bank_i),
      .flat_o (src_flat[g])
    );
    assign phys                         = map_q[src_flat[g]];
    assign src_phys_o[g*PHYS_W +: PHYS_W] = phys;
    assign src_rdy_o[g]                 = rdy_q[phys];
  end

  rn_flatten #(.INT_ARCH(INT_ARCH), .FP_ARCH(FP_ARCH), .NUM_BANKS(NUM_BANKS),
               .ARCH_W(ARCH_W), .BANK_W(BANK_W), .FLAT_W(FLAT_W)) u_dst_flat (
    .arch_i (dst_idx_i),
    .bank_i (bank_i),
    .flat_o (dst_flat)
  );

  assign walking     = (walk_q == WALK_SQUASH);
  assign hist_empty  = (hist_cnt == '0);
  assign hist_full   = (32'(hist_cnt) == HIST_DEPTH);
  assign ren_ready_o = !walking && !squash_i && !free_empty && !hist_full;
  assign alloc       = ren_valid_i && dst_valid_i && ren_ready_o;
  assign undo        = walking && !hist_empty && (yng_seq > walk_seq_q);
  assign retire      = commit_i && !walking && !hist_empty && (old_seq <= commit_seq_i);
  // undo needs walking, retire needs idle: never both
  assign free_push    = undo || retire;
  assign free_push_id = undo ? yng_new : old_prev;
  assign dst_prev_o   = map_q[dst_flat];
  assign squash_busy_o = walking;

  rn_free_list #(.DEPTH(FREE_N), .BASE(FLAT_REGS), .PHYS_W(PHYS_W), .CNT_W(FCNT_W)) u_free (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pop_i     (alloc),
    .push_i    (free_push),
    .push_id_i (free_push_id),
    .head_o    (dst_phys_o),
    .empty_o   (free_empty),
    .cnt_o     (free_cnt)
  );

  rn_history #(.DEPTH(HIST_DEPTH), .SEQ_W(SEQ_W), .FLAT_W(FLAT_W),
               .PHYS_W(PHYS_W), .CNT_W(HCNT_W)) u_hist (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (alloc),
    .push_seq_i  (seq_i),
    .push_arch_i (dst_flat),
    .push_new_i  (dst_phys_o),
    .push_prev_i (dst_prev_o),
    .pop_yng_i   (undo),
    .pop_old_i   (retire),
    .cnt_o       (hist_cnt),
    .old_seq_o   (old_seq),
    .old_prev_o  (old_prev),
    .yng_seq_o   (yng_seq),
    .yng_arch_o  (yng_arch),
    .yng_new_o   (yng_new),
    .yng_prev_o  (yng_prev)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      walk_q     <= WALK_IDLE;
      walk_seq_q <= '0;
    end else if (squash_i) begin
      walk_q     <= WALK_SQUASH;
      walk_seq_q <= squash_seq_i;
    end else if (walking && !undo) begin
      walk_q     <= WALK_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int f = 0; f < FLAT_REGS; f++) map_q[f] <= PHYS_W'(f);
    end else if (alloc) begin
      map_q[dst_flat] <= dst_phys_o;
    end else if (undo) begin
      map_q[yng_arch] <= yng_prev;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= '1;
    end else begin
      if (wb_valid_i) rdy_q[wb_phys_i]  <= 1'b1;
      if (alloc)      rdy_q[dst_phys_o] <= 1'b0;
    end
  end
endmodule

// File: rtl/rn_map_chk.sv
`timescale 1ns/1ps
module rn_map_chk #(
  parameter int FREE_N     = 8,
  parameter int HIST_DEPTH = 8,
  parameter int PHYS_W     = 5,
  parameter int FCNT_W     = 4,
  parameter int HCNT_W     = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ren_valid_i,
  input logic              dst_valid_i,
  input logic              ren_ready_o,
  input logic [PHYS_W-1:0] dst_phys_o,
  input logic [PHYS_W-1:0] dst_prev_o,
  input logic              squash_i,
  input logic              squash_busy_o,
  input logic [FCNT_W-1:0] free_cnt_i,
  input logic [HCNT_W-1:0] hist_cnt_i
);
  a_r5_pool_conserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(free_cnt_i) + 32'(hist_cnt_i) == FREE_N);

  a_r5_stall_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(hist_cnt_i) == HIST_DEPTH) |-> !ren_ready_o);

  a_r3_fresh_register: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_valid_i && dst_valid_i && ren_ready_o) |-> (dst_phys_o != dst_prev_o));

  a_r6_walk_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_i |=> squash_busy_o);

  a_r6_no_rename_in_walk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_busy_o |-> !ren_ready_o);
endmodule

bind rn_map rn_map_chk #(
  .FREE_N(FREE_N), .HIST_DEPTH(HIST_DEPTH), .PHYS_W(PHYS_W),
  .FCNT_W(FCNT_W), .HCNT_W(HCNT_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ren_valid_i   (ren_valid_i),
  .dst_valid_i   (dst_valid_i),
  .ren_ready_o   (ren_ready_o),
  .dst_phys_o    (dst_phys_o),
  .dst_prev_o    (dst_prev_o),
  .squash_i      (squash_i),
  .squash_busy_o (squash_busy_o),
  .free_cnt_i    (free_cnt),
  .hist_cnt_i    (hist_cnt)
);

// File: tb/rn_map_tb.sv
`timescale 1ns/1ps
module rn_map_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bank_i = 1'b0;
  logic       ren_valid_i = 1'b0, dst_valid_i = 1'b0;
  logic [5:0] src_idx_i = '0;
  logic [2:0] dst_idx_i = '0;
  logic [7:0] seq_i = '0;
  logic       ren_ready_o;
  logic [7:0] src_phys_o;
  logic [1:0] src_rdy_o;
  logic [3:0] dst_phys_o, dst_prev_o;
  logic       wb_valid_i = 1'b0;
  logic [3:0] wb_phys_i = '0;
  logic       squash_i = 1'b0;
  logic [7:0] squash_seq_i = '0;
  logic       commit_i = 1'b0;
  logic [7:0] commit_seq_i = '0;
  logic       squash_busy_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  rn_map #(.INT_ARCH(4), .FP_ARCH(4), .NUM_BANKS(2), .INT_PHYS(10), .FP_PHYS(6),
           .NUM_SRC(2), .HIST_DEPTH(3), .SEQ_W(8)) u_dut (
    .clk_i, .rst_ni, .bank_i, .ren_valid_i, .dst_valid_i, .src_idx_i, .dst_idx_i,
    .seq_i, .ren_ready_o, .src_phys_o, .src_rdy_o, .dst_phys_o, .dst_prev_o,
    .wb_valid_i, .wb_phys_i, .squash_i, .squash_seq_i, .commit_i, .commit_seq_i,
    .squash_busy_o
  );

  // bank | src0 | src1 | dst | seq | exp src0 phys | exp src1 phys | exp rdy {1,0} | exp new | exp prev
  localparam logic [35:0] TBL [6] = '{
    {1'b0, 3'd1, 3'd5, 3'd2, 8'd1, 4'd1,  4'd5,  2'b11, 4'd12, 4'd2},
    {1'b1, 3'd2, 3'd6, 3'd2, 8'd2, 4'd10, 4'd6,  2'b11, 4'd13, 4'd10},
    {1'b0, 3'd2, 3'd4, 3'd5, 8'd3, 4'd12, 4'd4,  2'b10, 4'd14, 4'd5},
    {1'b1, 3'd2, 3'd5, 3'd0, 8'd4, 4'd13, 4'd14, 2'b00, 4'd15, 4'd8},
    {1'b0, 3'd5, 3'd0, 3'd5, 8'd5, 4'd14, 4'd0,  2'b10, 4'd2,  4'd14},
    {1'b1, 3'd0, 3'd3, 3'd3, 8'd6, 4'd15, 4'd11, 2'b10, 4'd10, 4'd11}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic set_in(input logic b, input logic [2:0] s0, input logic [2:0] s1,
                        input logic [2:0] d, input logic [7:0] sq, input logic v);
    bank_i = b; src_idx_i = {s1, s0}; dst_idx_i = d; seq_i = sq;
    ren_valid_i = v; dst_valid_i = v;
    #2;
  endtask

  task automatic wait_walk(output int n);
    n = 0;
    while (squash_busy_o && n < 20) begin
      step();
      n++;
    end
    #2;
  endtask

  initial begin
    int n;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R8 reset state, R1 bank-1 integer lands above the fp range
    set_in(1'b1, 3'd7, 3'd0, 3'd3, 8'd0, 1'b0);
    chk("R8 ready after reset", ren_ready_o, 1);
    chk("R8 not busy after reset", squash_busy_o, 0);
    chk("R8 fp 7 identity map", src_phys_o[3:0], 7);
    chk("R8 all ready", src_rdy_o, 2'b11);
    chk("R8 first spare at free head", dst_phys_o, 12);
    chk("R1 bank1 int 3 -> flat 11", dst_prev_o, 11);
    chk("R1 bank1 int 0 -> flat 8", src_phys_o[7:4], 8);

    // table walk: rename, then commit that instruction
    for (int i = 0; i < 6; i++) begin
      set_in(TBL[i][35], TBL[i][34:32], TBL[i][31:29], TBL[i][28:26], TBL[i][25:18], 1'b1);
      chk("R5 ready before rename", ren_ready_o, 1);
      chk("R2 src0 phys", src_phys_o[3:0], TBL[i][17:14]);
      chk("R2 src1 phys", src_phys_o[7:4], TBL[i][13:10]);
      chk("R2 src ready bits", src_rdy_o, TBL[i][9:8]);
      chk("R3 new phys", dst_phys_o, TBL[i][7:4]);
      chk("R3 prev phys", dst_prev_o, TBL[i][3:0]);
      step();
      ren_valid_i = 1'b0; dst_valid_i = 1'b0;
      commit_i = 1'b1; commit_seq_i = TBL[i][25:18];
      step();
      commit_i = 1'b0;
    end

    // R4 writeback of 12 (mapped to bank0 int 2)
    set_in(1'b0, 3'd2, 3'd0, 3'd0, 8'd0, 1'b0);
    chk("R4 bit clear before writeback", src_rdy_o[0], 0);
    wb_valid_i = 1'b1; wb_phys_i = 4'd12;
    step();
    wb_valid_i = 1'b0;
    #2;
    chk("R4 bit set after writeback", src_rdy_o[0], 1);
    chk("R4 mapping unchanged", src_phys_o[3:0], 12);

    // R5 fill history: A,B,C
    set_in(1'b0, 3'd0, 3'd0, 3'd1, 8'd10, 1'b1);
    chk("R3 A new", dst_phys_o, 5);
    step();
    set_in(1'b0, 3'd0, 3'd0, 3'd1, 8'd11, 1'b1);
    chk("R3 B new", dst_phys_o, 8);
    chk("R3 B prev is A new", dst_prev_o, 5);
    step();
    set_in(1'b0, 3'd0, 3'd0, 3'd6, 8'd12, 1'b1);
    chk("R3 C new", dst_phys_o, 14);
    step();
    set_in(1'b0, 3'd0, 3'd0, 3'd1, 8'd13, 1'b1);
    chk("R5 stall with full history", ren_ready_o, 0);
    step();
    set_in(1'b0, 3'd0, 3'd0, 3'd1, 8'd0, 1'b0);
    chk("R5 stalled rename left map", dst_prev_o, 8);
    chk("R5 stalled rename left free list", dst_phys_o, 11);

    // R6 squash back to seq 10
    squash_i = 1'b1; squash_seq_i = 8'd10;
    #2;
    chk("R6 ready low during squash request", ren_ready_o, 0);
    step();
    squash_i = 1'b0;
    #2;
    chk("R6 busy after squash", squash_busy_o, 1);
    wait_walk(n);
    chk("R6 walk length two pops", n, 3);
    set_in(1'b0, 3'd6, 3'd0, 3'd1, 8'd0, 1'b0);
    chk("R6 int 1 restored to A", dst_prev_o, 5);
    chk("R6 fp 6 restored", src_phys_o[3:0], 6);
    chk("R6 free head unchanged", dst_phys_o, 11);
    chk("R6 ready after walk", ren_ready_o, 1);

    // R7 commit too old, then D and E fill history
    commit_i = 1'b1; commit_seq_i = 8'd9;
    step();
    commit_i = 1'b0;
    set_in(1'b0, 3'd0, 3'd0, 3'd7, 8'd20, 1'b1);
    chk("R3 D new", dst_phys_o, 11);
    chk("R3 D prev", dst_prev_o, 7);
    step();
    set_in(1'b0, 3'd0, 3'd0, 3'd7, 8'd21, 1'b1);
    chk("R3 E new from squashed return", dst_phys_o, 14);
    step();
    set_in(1'b0, 3'd0, 3'd0, 3'd0, 8'd0, 1'b0);
    chk("R7 young entry kept by commit", ren_ready_o, 0);
    commit_i = 1'b1; commit_seq_i = 8'd20;
    step();
    step();
    commit_i = 1'b0;
    #2;
    chk("R7 two retired, ready", ren_ready_o, 1);
    chk("R7 free head", dst_phys_o, 8);

    // R6 squash undoes E after commits
    squash_i = 1'b1; squash_seq_i = 8'd20;
    step();
    squash_i = 1'b0;
    wait_walk(n);
    chk("R6 one-pop walk", n, 2);
    set_in(1'b0, 3'd7, 3'd0, 3'd0, 8'd0, 1'b0);
    chk("R6 fp 7 restored to D", src_phys_o[3:0], 11);
    chk("R6 free head after walk", dst_phys_o, 8);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule